// File: doc/BRIEF.md
# USB Device Control and Event Interrupt Registers

This block is the register front end of a USB device controller. It keeps a control register and an event register behind a small synchronous register bus. The control register decides whether the D+ pull-up is enabled, sends single-cycle remote wake-up requests to the serial engine, and arms a CPU reset that fires on the next USB bus reset. The event register latches one-cycle hardware event pulses. An enable register masks those events, and the enabled events are combined into one general interrupt line.

The CPU-reset arming is handled by a small state machine with three states. In `ARM_IDLE`, a bus reset has no effect. In `ARM_READY`, the next bus reset fires. In `ARM_FIRING`, the reset output is held high for `RST_CYCLES` cycles. The state machine moves between these states on four named transitions:

- T_ARM: from `ARM_IDLE` to `ARM_READY`, when firmware writes 1 to the arm bit while `usb_en_i` is high.
- T_FIRE: from `ARM_READY` to `ARM_FIRING`, on a `bus_rst_i` pulse.
- T_DONE: from `ARM_FIRING` back to `ARM_READY`, when the cycle count expires.
- T_DISARM: from any armed state to `ARM_IDLE`, when firmware writes 0 to the arm bit or `usb_en_i` is low.

The block's own registers are never reset by `cpu_rst_o`. Only `rst_ni` resets them.

Top module: `usbdev_ctl_regs`

Address map (2-bit address):

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Events |
| 2 | Enables |
| 3 | Unused, always reads 0x00 |

## Requirements
- R1: After reset, the registers read as follows: Control 0x01, Events 0x00, Enables 0x00. The outputs `pullup_en_o`, `irq_o`, `cpu_rst_o` and `wkup_req_o` are all low.
- R2: Reads return the contents of the addressed register on `rdata_o`, one cycle after the address is presented. The following bits always read 0: Control bits 7 to 3, Events bits 7 and 1, Enables bits 7 and 1, and every bit at address 3.
- R3: Control bit 0 is the detach bit. `pullup_en_o` is the inverse of this bit and changes in the cycle after the write.
- R4: Writing 1 to Control bit 1 raises `wkup_req_o` for exactly one cycle, the cycle after the write. This bit always reads 0. Writing 0 to it produces no pulse.
- R5: Control bit 2 is the arm bit. When it is set, a one-cycle `bus_rst_i` pulse makes `cpu_rst_o` go high in the next cycle and stay high for `RST_CYCLES` cycles. After that the arm bit stays set.
- R6: The arm bit is cleared when firmware writes 0 to it or when `usb_en_i` is low. A write of 1 to it is ignored while `usb_en_i` is low. While the arm bit is clear, `bus_rst_i` never raises `cpu_rst_o`.
- R7: A one-cycle pulse on an event input sets its bit in the Events register. The bit positions are:

  | Bit | Event input |
  |---|---|
  | 6 | `evt_uprsm_i` |
  | 5 | `evt_eorsm_i` |
  | 4 | `evt_wakeup_i` |
  | 3 | `evt_eorst_i` |
  | 2 | `evt_sof_i` |
  | 0 | `evt_susp_i` |

- R8: Writing 0 to an Events bit clears it. Writing 1 to an Events bit leaves it unchanged. Events writes have effect only while `usb_clk_en_i` is high.
- R9: If an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R10: `irq_o` is the OR of every Events bit ANDed with the matching Enables bit. It is registered, so it follows the register contents one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usb_en_i | input | 1 | Controller enable. When low, the CPU-reset arming is cleared |
| usb_clk_en_i | input | 1 | USB clock enable. Gates writes that clear event bits |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| bus_rst_i | input | 1 | Pulse: a USB bus reset was detected |
| evt_uprsm_i | input | 1 | Pulse: upstream resume was sent |
| evt_eorsm_i | input | 1 | Pulse: end of a resume started by the host |
| evt_wakeup_i | input | 1 | Pulse: wake-up activity |
| evt_eorst_i | input | 1 | Pulse: end of bus reset |
| evt_sof_i | input | 1 | Pulse: start of frame |
| evt_susp_i | input | 1 | Pulse: suspend |
| pullup_en_o | output | 1 | D+ pull-up enable |
| wkup_req_o | output | 1 | Single-cycle remote wake-up request |
| cpu_rst_o | output | 1 | Reset for the CPU and the other peripherals |
| irq_o | output | 1 | General interrupt |

## Verification
Some properties are checked by assertions on every cycle:

- The wake-up strobe never lasts more than one cycle.
- The pull-up follows the last detach write.
- A low controller enable silences the CPU reset.
- No event bit is lost when a set pulse and a clear arrive together.
- No event bit is cleared while the USB clock enable is low.
- The interrupt stays low when no enabled event is pending.
- Reserved read bits stay zero.

Other behaviours only the bench scenarios can show:

- The exact length of the CPU reset pulse.
- That the arm bit survives a fired reset.
- That arming writes are ignored while the controller is disabled.
- That writing ones to event bits leaves them intact.
- The one-cycle lag of the interrupt behind the Enables register.

// File: rtl/usbdev_regs_pkg.sv
package usbdev_regs_pkg;

    localparam int REG_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_IEN  = 2'd2;

    // Control bit positions
    localparam int B_DETACH = 0;
    localparam int B_WKUP   = 1;
    localparam int B_ARM    = 2;

    // Event bit positions
    localparam int F_SUSP  = 0;
    localparam int F_SOF   = 2;
    localparam int F_EORST = 3;
    localparam int F_WAKE  = 4;
    localparam int F_EORSM = 5;
    localparam int F_UPRSM = 6;

    localparam logic [REG_W-1:0] FLAG_MASK = 8'h7D;

    typedef enum logic [1:0] {
        ARM_IDLE   = 2'd0,
        ARM_READY  = 2'd1,
        ARM_FIRING = 2'd2
    } arm_state_e;

endpackage

// File: rtl/usbdev_ctrl_reg.sv
module usbdev_ctrl_reg
    import usbdev_regs_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             usb_en_i,
    input  logic             wr_i,
    input  logic [2:0]       wbits_i,
    input  logic             bus_rst_i,
    output logic [REG_W-1:0] ctl_o,
    output logic             pullup_en_o,
    output logic             wkup_req_o,
    output logic             cpu_rst_o
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    arm_state_e       state_q;
    arm_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             detach_q;
    logic             wkup_q;
    logic             arm_wr1;
    logic             arm_wr0;

    assign arm_wr1 = wr_i && wbits_i[B_ARM];
    assign arm_wr0 = wr_i && !wbits_i[B_ARM];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: begin
                if (usb_en_i && arm_wr1) begin
                    state_d = ARM_READY;                 // T_ARM
                end
            end
            ARM_READY: begin
                if (!usb_en_i || arm_wr0) begin
                    state_d = ARM_IDLE;                  // T_DISARM
                end else if (bus_rst_i) begin
                    state_d = ARM_FIRING;                // T_FIRE
                end
            end
            ARM_FIRING: begin
                if (!usb_en_i || arm_wr0) begin
                    state_d = ARM_IDLE;                  // T_DISARM
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ARM_READY;                 // T_DONE
                end
            end
            default: state_d = ARM_IDLE;
        endcase
    end

    // State register and firing counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ARM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARM_FIRING) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Detach bit and wake-up strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            detach_q <= 1'b1;
            wkup_q   <= 1'b0;
        end else begin
            wkup_q <= wr_i && wbits_i[B_WKUP];
            if (wr_i) begin
                detach_q <= wbits_i[B_DETACH];
            end
        end
    end

    // Outputs
    always_comb begin
        cpu_rst_o         = (state_q == ARM_FIRING);
        pullup_en_o       = !detach_q;
        wkup_req_o        = wkup_q;
        ctl_o             = '0;
        ctl_o[B_DETACH]   = detach_q;
        ctl_o[B_ARM]      = (state_q != ARM_IDLE);
    end

    p_wkup_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wkup_req_o |=> !wkup_req_o);

    p_pullup_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (pullup_en_o == !$past(wbits_i[B_DETACH])));

    p_no_rst_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !usb_en_i |=> !cpu_rst_o);

endmodule

// File: rtl/usbdev_irq_reg.sv
module usbdev_irq_reg
    import usbdev_regs_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             usb_clk_en_i,
    input  logic             wr_flag_i,
    input  logic             wr_ien_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] set_i,
    output logic [REG_W-1:0] flag_o,
    output logic [REG_W-1:0] ien_o,
    output logic             irq_o
);

    logic [REG_W-1:0] flag_q;
    logic [REG_W-1:0] ien_q;
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] clr_v;
    logic             irq_q;

    assign set_v = set_i & FLAG_MASK;

    always_comb begin
        clr_v = '0;
        if (wr_flag_i && usb_clk_en_i) begin
            clr_v = ~wdata_i & FLAG_MASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= '0;
            ien_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            // Set pulses take priority over clearing writes
            flag_q <= (flag_q & ~clr_v) | set_v;
            if (wr_ien_i) begin
                ien_q <= wdata_i & FLAG_MASK;
            end
            irq_q <= |(flag_q & ien_q);
        end
    end

    assign flag_o = flag_q;
    assign ien_o  = ien_q;
    assign irq_o  = irq_q;

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_v != '0) |=> (($past(set_v) & ~flag_q) == '0));

    p_clr_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !usb_clk_en_i |=> (($past(flag_q) & ~flag_q) == '0));

    p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flag_q & ien_q) == '0) |=> !irq_o);

endmodule

// File: rtl/usbdev_ctl_regs.sv
module usbdev_ctl_regs
    import usbdev_regs_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        usb_en_i,
    input  logic        usb_clk_en_i,
    input  logic [1:0]  addr_i,
    input  logic        we_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    input  logic        bus_rst_i,
    input  logic        evt_uprsm_i,
    input  logic        evt_eorsm_i,
    input  logic        evt_wakeup_i,
    input  logic        evt_eorst_i,
    input  logic        evt_sof_i,
    input  logic        evt_susp_i,
    output logic        pullup_en_o,
    output logic        wkup_req_o,
    output logic        cpu_rst_o,
    output logic        irq_o
);

    logic [REG_W-1:0] ctl_v;
    logic [REG_W-1:0] flag_v;
    logic [REG_W-1:0] ien_v;
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] rd_d;
    logic [REG_W-1:0] rd_q;

    always_comb begin
        set_v          = '0;
        set_v[F_UPRSM] = evt_uprsm_i;
        set_v[F_EORSM] = evt_eorsm_i;
        set_v[F_WAKE]  = evt_wakeup_i;
        set_v[F_EORST] = evt_eorst_i;
        set_v[F_SOF]   = evt_sof_i;
        set_v[F_SUSP]  = evt_susp_i;
    end

    usbdev_ctrl_reg #(
        .RST_CYCLES (RST_CYCLES)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .usb_en_i    (usb_en_i),
        .wr_i        (we_i && (addr_i == A_CTRL)),
        .wbits_i     (wdata_i[2:0]),
        .bus_rst_i   (bus_rst_i),
        .ctl_o       (ctl_v),
        .pullup_en_o (pullup_en_o),
        .wkup_req_o  (wkup_req_o),
        .cpu_rst_o   (cpu_rst_o)
    );

    usbdev_irq_reg u_irq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .usb_clk_en_i (usb_clk_en_i),
        .wr_flag_i    (we_i && (addr_i == A_FLAG)),
        .wr_ien_i     (we_i && (addr_i == A_IEN)),
        .wdata_i      (wdata_i),
        .set_i        (set_v),
        .flag_o       (flag_v),
        .ien_o        (ien_v),
        .irq_o        (irq_o)
    );

    always_comb begin
        unique case (addr_i)
            A_CTRL:  rd_d = ctl_v;
            A_FLAG:  rd_d = flag_v;
            A_IEN:   rd_d = ien_v;
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q;

    p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (rdata_o[7] == 1'b0 && rdata_o[1] == 1'b0));

endmodule

// File: tb/usbdev_ctl_regs_bench.sv
module usbdev_ctl_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CYCLES = 4;
    localparam int NVEC = 7;

    typedef struct packed {
        logic [1:0] waddr;
        logic [7:0] wdata;
        logic [1:0] raddr;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'h00, 2'd0, 8'h00},   // R3 detach cleared
        '{2'd0, 8'hFD, 2'd0, 8'h05},   // R2 reserved zero, R5 arm set
        '{2'd0, 8'h02, 2'd0, 8'h00},   // R4 wake reads 0, R6 arm cleared
        '{2'd2, 8'hFF, 2'd2, 8'h7D},   // R2 enable reserved bits
        '{2'd2, 8'h14, 2'd2, 8'h14},   // R10 enable read/write
        '{2'd3, 8'hFF, 2'd3, 8'h00},   // R2 unused address
        '{2'd0, 8'h01, 2'd0, 8'h01}    // R3 detach set
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_en = 1'b1;
    logic       usb_clk_en = 1'b1;
    logic [1:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       bus_rst = 1'b0;
    logic       e_uprsm = 1'b0, e_eorsm = 1'b0, e_wake = 1'b0;
    logic       e_eorst = 1'b0, e_sof = 1'b0, e_susp = 1'b0;
    logic       pullup_en, wkup_req, cpu_rst, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbdev_ctl_regs #(.RST_CYCLES(RST_CYCLES)) u_usbdev_ctl_regs (
        .clk_i(clk), .rst_ni(rst_n), .usb_en_i(usb_en), .usb_clk_en_i(usb_clk_en),
        .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
        .bus_rst_i(bus_rst), .evt_uprsm_i(e_uprsm), .evt_eorsm_i(e_eorsm),
        .evt_wakeup_i(e_wake), .evt_eorst_i(e_eorst), .evt_sof_i(e_sof),
        .evt_susp_i(e_susp), .pullup_en_o(pullup_en), .wkup_req_o(wkup_req),
        .cpu_rst_o(cpu_rst), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        @(negedge clk);
        d = rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pullup", {7'd0, pullup_en}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 cpu_rst", {7'd0, cpu_rst}, 8'h00);
        chk("R1 wkup", {7'd0, wkup_req}, 8'h00);
        rd(2'd0, v); chk("R1 ctrl", v, 8'h01);
        rd(2'd1, v); chk("R1 events", v, 8'h00);
        rd(2'd2, v); chk("R1 enables", v, 8'h00);

        // Table walk (R2 R3 R4 R5 R6 R10)
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].waddr, VECS[i].wdata);
            rd(VECS[i].raddr, v);
            chk($sformatf("R2 vector %0d", i), v, VECS[i].exp);
        end

        // R3 pull-up follows detach
        wr(2'd0, 8'h00);
        chk("R3 pullup on", {7'd0, pullup_en}, 8'h01);
        wr(2'd0, 8'h01);
        chk("R3 pullup off", {7'd0, pullup_en}, 8'h00);

        // R4 wake-up strobe
        @(negedge clk); addr = 2'd0; wdata = 8'h03; we = 1'b1;
        @(negedge clk); we = 1'b0;
        chk("R4 pulse high", {7'd0, wkup_req}, 8'h01);
        @(negedge clk);
        chk("R4 pulse ends", {7'd0, wkup_req}, 8'h00);
        @(negedge clk); addr = 2'd0; wdata = 8'h01; we = 1'b1;
        @(negedge clk); we = 1'b0;
        chk("R4 write zero no pulse", {7'd0, wkup_req}, 8'h00);

        // R5 armed bus reset
        wr(2'd0, 8'h04);
        @(negedge clk); bus_rst = 1'b1;
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); bus_rst = 1'b0;
            if (cpu_rst) hi++;
        end
        chk("R5 reset length", 8'(hi), 8'(RST_CYCLES));
        rd(2'd0, v); chk("R5 arm kept", v, 8'h04);

        // R6 disable clears arm
        @(negedge clk); usb_en = 1'b0;
        @(negedge clk); usb_en = 1'b1;
        rd(2'd0, v); chk("R6 disable clears", v, 8'h00);
        @(negedge clk); bus_rst = 1'b1;
        hi = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); bus_rst = 1'b0;
            if (cpu_rst) hi++;
        end
        chk("R6 no reset disarmed", 8'(hi), 8'h00);
        usb_en = 1'b0;
        wr(2'd0, 8'h04);
        usb_en = 1'b1;
        rd(2'd0, v); chk("R6 arm ignored while disabled", v, 8'h00);
        wr(2'd0, 8'h04);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R6 write zero disarms", v, 8'h00);

        // R7 each event sets its own bit
        @(negedge clk); e_uprsm = 1'b1; @(negedge clk); e_uprsm = 1'b0;
        rd(2'd1, v); chk("R7 uprsm bit6", v, 8'h40);
        wr(2'd1, 8'h00);
        @(negedge clk); e_sof = 1'b1; @(negedge clk); e_sof = 1'b0;
        rd(2'd1, v); chk("R7 sof bit2", v, 8'h04);
        wr(2'd1, 8'h00);
        @(negedge clk); e_susp = 1'b1; @(negedge clk); e_susp = 1'b0;
        rd(2'd1, v); chk("R7 susp bit0", v, 8'h01);
        @(negedge clk);
        e_uprsm = 1'b1; e_eorsm = 1'b1; e_wake = 1'b1; e_eorst = 1'b1; e_sof = 1'b1; e_susp = 1'b1;
        @(negedge clk);
        e_uprsm = 1'b0; e_eorsm = 1'b0; e_wake = 1'b0; e_eorst = 1'b0; e_sof = 1'b0; e_susp = 1'b0;
        rd(2'd1, v); chk("R7 all events", v, 8'h7D);

        // R8 write-one no effect, write-zero clears, gated by clock enable
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R8 write ones keep", v, 8'h7D);
        wr(2'd1, 8'h3D);
        rd(2'd1, v); chk("R8 clear bit6", v, 8'h3D);
        usb_clk_en = 1'b0;
        wr(2'd1, 8'h00);
        usb_clk_en = 1'b1;
        rd(2'd1, v); chk("R8 gated clear ignored", v, 8'h3D);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R8 clear all", v, 8'h00);

        // R9 set wins over clear
        @(negedge clk); addr = 2'd1; wdata = 8'h00; we = 1'b1; e_sof = 1'b1;
        @(negedge clk); we = 1'b0; e_sof = 1'b0;
        rd(2'd1, v); chk("R9 set wins", v, 8'h04);

        // R10 interrupt gating (events = 0x04)
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk("R10 masked", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h04);
        chk("R10 not yet", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R10 enabled", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h00);
        @(negedge clk);
        chk("R10 cleared", {7'd0, irq}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule